// File: doc/BRIEF.md
# Serial Audio Clock Generator

This block produces the clocks that a serial audio link needs. Its input clock runs at 768 times the sample rate. When it is the clock master it makes three outputs from that clock: a converter master clock at 256Fs or 384Fs, a bit clock at 32Fs or 64Fs, and a word clock at 1Fs that marks left and right halves of each stereo sample. A single position counter produces all three, so their edges stay in a fixed phase relation.

When it is a clock follower, the block generates nothing. The master clock output stays low and the output enables for the bit and word clock pins are deasserted. The bit and word clocks that arrive from the external master are passed straight through to the serial data logic.

The mode and the two ratio selects are captured only while reset is high. Changing them therefore needs a reset, and that reset also restarts the counter, so a ratio change never produces a partial clock pulse.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its position counter and drives `mclk_o`, `bclk_o` and `wclk_o` low on the following cycle.
- R2: In master mode, `wclk_o` has a period of 768 input cycles. It is low for the first 384 cycles after reset and high for the next 384.
- R3: In master mode, `bclk_o` has a period of 12 input cycles (64Fs) when `bclk_64_sel`=1 and 24 cycles (32Fs) when it is 0. Each period starts with its low half.
- R4: In master mode with `mclk_384_sel`=1, `mclk_o` is a divide-by-2 of `clk`. It is high in every cycle whose position since reset is odd.
- R5: In master mode with `mclk_384_sel`=0, `mclk_o` is a divide-by-3 of `clk` with 50% duty cycle. At position p, with p mod 3 equal to 1, it rises after the rising edge and stays high until the falling edge in position p+1.
- R6: In master mode, `wclk_o` changes only on a rising edge at which `bclk_o` goes from high to low.
- R7: In follower mode (`master_en`=0 at reset), `mclk_o`, `bclk_o` and `wclk_o` are low, `bclk_oe` and `wclk_oe` are 0, and `core_bclk`/`core_wclk` follow `ext_bclk`/`ext_wclk`.
- R8: The inputs `master_en`, `mclk_384_sel` and `bclk_64_sel` take effect only when sampled at a rising edge with `rst` high. Changing them at any other time has no effect on any output.
- R9: In master mode, `bclk_oe` and `wclk_oe` are 1, and `core_bclk`/`core_wclk` follow the generated `bclk_o`/`wclk_o`. The external clocks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at 768Fs |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| master_en | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| mclk_384_sel | input | 1 | 1 = 384Fs master clock, 0 = 256Fs |
| bclk_64_sel | input | 1 | 1 = 64Fs bit clock, 0 = 32Fs |
| ext_bclk | input | 1 | Bit clock from an external master |
| ext_wclk | input | 1 | Word clock from an external master |
| mclk_o | output | 1 | Converter master clock |
| bclk_o | output | 1 | Generated bit clock |
| wclk_o | output | 1 | Generated word clock |
| bclk_oe | output | 1 | Output enable for the bit clock pin |
| wclk_oe | output | 1 | Output enable for the word clock pin |
| core_bclk | output | 1 | Bit clock delivered to the serial data logic |
| core_wclk | output | 1 | Word clock delivered to the serial data logic |

## Verification
The bench samples every cycle twice, once before and once after the falling edge of `clk`. This catches a divide-by-3 master clock that misses its falling-edge half-phase: that clock would show 33% or 67% duty instead of 50%. Each run lasts two full frames, so an off-by-one in the wrap would show as a word clock period of 767 or 769 cycles, or as bit clock edges drifting against the word clock. The bench changes the ratio and mode inputs in the middle of a run. A design that captured them without a reset would switch clock rate mid-frame. In follower mode the bench toggles the external clocks. A design that still drove its pins or the master clock would be caught, and so would one that routed the wrong source to the serial data logic.

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen #(
  parameter int SLOT_W = 8,
  parameter int BCK64_BIT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic master_en,
  input  logic mclk_384_sel,
  input  logic bclk_64_sel,
  input  logic ext_bclk,
  input  logic ext_wclk,
  output logic mclk_o,
  output logic bclk_o,
  output logic wclk_o,
  output logic bclk_oe,
  output logic wclk_oe,
  output logic core_bclk,
  output logic core_wclk
);
  localparam int BCK32_BIT = BCK64_BIT + 1;
  localparam int WCLK_BIT  = SLOT_W - 1;

  logic cfg_master, cfg_m384, cfg_b64;
  logic [1:0] ph3;
  logic [SLOT_W-1:0] slot;
  logic tog, pulse3, pulse3_n, bclk_q, wclk_q;

  always_ff @(posedge clk)
    if (rst) begin
      cfg_master <= master_en;
      cfg_m384   <= mclk_384_sel;
      cfg_b64    <= bclk_64_sel;
    end

  wire clr = rst || !cfg_master;
  wire wrap3 = (ph3 == 2'd2);
  wire [1:0] ph3_nx = wrap3 ? 2'd0 : ph3 + 2'd1;
  wire [SLOT_W-1:0] slot_nx = wrap3 ? slot + 1'b1 : slot;

  always_ff @(posedge clk)
    if (clr) begin
      ph3    <= '0;
      slot   <= '0;
      tog    <= 1'b0;
      pulse3 <= 1'b0;
      bclk_q <= 1'b0;
      wclk_q <= 1'b0;
    end else begin
      ph3    <= ph3_nx;
      slot   <= slot_nx;
      tog    <= ~tog;
      pulse3 <= (ph3_nx == 2'd1);
      bclk_q <= cfg_b64 ? slot_nx[BCK64_BIT] : slot_nx[BCK32_BIT];
      wclk_q <= slot_nx[WCLK_BIT];
    end

  always_ff @(negedge clk)
    pulse3_n <= clr ? 1'b0 : pulse3;

  assign mclk_o    = cfg_master & (cfg_m384 ? tog : (pulse3 | pulse3_n));
  assign bclk_o    = bclk_q;
  assign wclk_o    = wclk_q;
  assign bclk_oe   = cfg_master;
  assign wclk_oe   = cfg_master;
  assign core_bclk = cfg_master ? bclk_q : ext_bclk;
  assign core_wclk = cfg_master ? wclk_q : ext_wclk;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!bclk_o && !wclk_o && !tog && !pulse3));

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (clr)
    (slot == '1 && wrap3) |=> (slot == '0 && ph3 == 2'd0));

  assert_div2_toggles_R4: assert property (@(posedge clk) disable iff (clr)
    cfg_m384 |=> (tog != $past(tog)));

  assert_div3_pulse_R5: assert property (@(posedge clk) disable iff (clr)
    pulse3 |=> !pulse3);

  assert_wclk_on_bclk_fall_R6: assert property (@(posedge clk) disable iff (clr)
    (wclk_q != $past(wclk_q)) |-> ($past(bclk_q) && !bclk_q));

  assert_follower_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_master |-> (!mclk_o && !bclk_oe && !wclk_oe && !bclk_o && !wclk_o));

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable({cfg_master, cfg_m384, cfg_b64}));
endmodule

// File: tb/audio_clkgen_bench.sv
`timescale 1ns/1ps
module audio_clkgen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_en = 1'b1, mclk_384_sel = 1'b0, bclk_64_sel = 1'b1;
  logic ext_bclk = 1'b0, ext_wclk = 1'b0;
  logic mclk_o, bclk_o, wclk_o, bclk_oe, wclk_oe, core_bclk, core_wclk;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  audio_clkgen u_audio_clkgen (
    .clk(clk), .rst(rst), .master_en(master_en), .mclk_384_sel(mclk_384_sel),
    .bclk_64_sel(bclk_64_sel), .ext_bclk(ext_bclk), .ext_wclk(ext_wclk),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .wclk_o(wclk_o), .bclk_oe(bclk_oe),
    .wclk_oe(wclk_oe), .core_bclk(core_bclk), .core_wclk(core_wclk));

  // {master, m384, b64}
  localparam logic [2:0] CFG [5] = '{3'b101, 3'b100, 3'b111, 3'b110, 3'b011};
  localparam int RUN = 1540;

  task automatic chk(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic e_bck(int p, logic b64);
    int s = (p % 768) / 3;
    return b64 ? s[1] : s[2];
  endfunction
  function automatic logic e_wck(int p);
    int s = (p % 768) / 3;
    return s[7];
  endfunction
  function automatic logic e_mck(int p, logic m384, logic late);
    if (m384) return p[0];
    if (late) return (p % 3) == 1;
    return (p % 3) != 0;
  endfunction

  task automatic do_reset(logic [2:0] c);
    @(posedge clk); #1;
    {master_en, mclk_384_sel, bclk_64_sel} = c;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mclk in reset", mclk_o, 1'b0);
    chk("R1", "bclk in reset", bclk_o, 1'b0);
    chk("R1", "wclk in reset", wclk_o, 1'b0);
    rst = 1'b0;
  endtask

  // run cycles k0..k1-1 after reset with model config c (already in reset)
  task automatic run_master(logic [2:0] c, int k0, int k1);
    logic pb, pw;
    pb = 1'b0; pw = 1'b0;
    for (int k = k0; k < k1; k++) begin
      @(posedge clk); #1;
      ext_bclk = $urandom_range(1); ext_wclk = $urandom_range(1);
      chk("R3", "bclk", bclk_o, e_bck(k, c[0]));
      chk("R2", "wclk", wclk_o, e_wck(k));
      chk(c[1] ? "R4" : "R5", "mclk early", mclk_o, e_mck(k, c[1], 1'b0));
      if (k > k0 && wclk_o != pw)
        chk("R6", "bclk fell with wclk", pb & ~bclk_o, 1'b1);
      pb = bclk_o; pw = wclk_o;
      #2;
      chk(c[1] ? "R4" : "R5", "mclk late", mclk_o, e_mck(k, c[1], 1'b1));
      chk("R9", "oe", bclk_oe & wclk_oe, 1'b1);
      chk("R9", "core_bclk", core_bclk, e_bck(k, c[0]));
      chk("R9", "core_wclk", core_wclk, e_wck(k));
    end
  endtask

  task automatic run_follower(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      ext_bclk = $urandom_range(1); ext_wclk = $urandom_range(1);
      #2;
      chk("R7", "mclk low", mclk_o, 1'b0);
      chk("R7", "pins low", bclk_o | wclk_o, 1'b0);
      chk("R7", "oe off", bclk_oe | wclk_oe, 1'b0);
      chk("R7", "core_bclk", core_bclk, ext_bclk);
      chk("R7", "core_wclk", core_wclk, ext_wclk);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      do_reset(CFG[i]);
      if (CFG[i][2]) run_master(CFG[i], 1, RUN);
      else run_follower(200);
    end
    // R8: change config without reset; old clocks continue
    do_reset(3'b101);
    run_master(3'b101, 1, 60);
    {master_en, mclk_384_sel, bclk_64_sel} = 3'b010;
    run_master(3'b101, 60, 900);
    // R8: after reset the new follower setting applies
    do_reset(3'b010);
    run_follower(50);
    {master_en, mclk_384_sel, bclk_64_sel} = 3'b111;
    run_follower(50);
    // R1: reset from a running master state
    do_reset(3'b111);
    run_master(3'b111, 1, 400);
    do_reset(3'b100);
    run_master(3'b100, 1, 30);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule